// File: doc/BRIEF.md
# Shared-Memory Time-Slot Timing Generator

This block derives every clock and strobe that a small computer needs when its video system and its CPU take turns on one RAM. A single fast master clock (nominally 32.64 MHz, also used directly as the video dot clock) drives a free-running synchronous counter. All other outputs are decoded from that counter and registered on the master clock. The counter period is 32 master clocks, about one microsecond.

Each 32-clock period holds two slots of 16 clocks. The video slot comes first and the CPU slot follows. An address-select output steers the shared address bus to the video address source or to the CPU address source. Each slot is split into four states of four clocks each. A two-clock character strobe fires at the start of the third state of the video slot. That strobe loads one 16-bit character row into the video shifters and moves the fetched 16-bit word onto an 8-bit data bus. A byte-select output picks the high byte in the first clock of the strobe and the low byte in the second. The block also gives binary submultiples of the master clock and a complementary pair of CPU clocks.

Top module: `tsg_timing_gen`

## Requirements
- R1: While `rst_i` is high at a rising edge, the outputs take the count-zero state after that edge: `div_o`=0, `slot_cpu_o`=0, `addr_sel_o`=0, `state_o`=0, `latch_o`=0, `byte_hi_o`=0, `cpu_clk_o`=0, `cpu_clk_n_o`=1.
- R2: Let c be the number of rising edges since the last reset edge, modulo 32. `div_o[k]` equals bit k of c for k=0..3. So `div_o[k]` toggles every 2^k master clocks, giving half, quarter, eighth and sixteenth rates.
- R3: `slot_cpu_o` is 0 (video slot) for c=0..15 and 1 (CPU slot) for c=16..31, repeating every 32 clocks.
- R4: `addr_sel_o` is 1 (CPU address source) exactly when the CPU slot is active, and 0 (video address source) during the video slot.
- R5: `state_o` equals bits 3:2 of c, encoded 0=T1, 1=T2, 2=T3, 3=T4. It advances every 4 clocks and restarts at T1 at the start of each slot.
- R6: `latch_o` is high exactly at c=8 and c=9, which is the first two clocks of T3 in the video slot. It is never high in the CPU slot. This gives one 2-clock pulse per 32 clocks.
- R7: `byte_hi_o` is 1 only at c=9, the second clock of the strobe. It is 0 at c=8 (high byte first) and at all other times.
- R8: `cpu_clk_o` equals bit 1 of c (a quarter-rate CPU clock), and `cpu_clk_n_o` is always its complement.
- R9: A reset applied in the middle of a period restarts the sequence at c=0, whatever the current count is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, also the video dot clock |
| rst_i | input | 1 | Synchronous active-high reset |
| div_o | output | 4 | Divided clocks; bit k runs at master/2^(k+1) |
| slot_cpu_o | output | 1 | 0 = video slot, 1 = CPU slot |
| addr_sel_o | output | 1 | Shared address bus select; 1 = CPU address |
| state_o | output | 2 | State within the slot, 0..3 = T1..T4 |
| latch_o | output | 1 | Character row latch strobe |
| byte_hi_o | output | 1 | Byte select for the 16-to-8 data path; 0 = high byte |
| cpu_clk_o | output | 1 | CPU clock |
| cpu_clk_n_o | output | 1 | Active-low complement of the CPU clock |

## Verification
The embedded assertions check the local invariants on every cycle. They cover the counter stepping by one, the strobe staying inside the video slot and starting in T3 with the high byte, the byte select never standing outside the strobe, state changes advancing by exactly one, a new slot starting in T1, and the CPU clock pair staying complementary. Absolute phase needs the bench's reference count after each reset. That covers where the strobe sits in the 32-clock period, its exact two-clock length, the slot boundaries and the divided-clock values. The bench compares every output against that count on every cycle, across random run lengths and resets at random points.

// File: rtl/tsg_pkg.sv
package tsg_pkg;

    // Counter geometry: one period = 2**TSG_CNT_W master clocks
    localparam int TSG_CNT_W     = 5;
    localparam int TSG_STATE_W   = 2;
    localparam int TSG_POS_W     = TSG_CNT_W - 1 - TSG_STATE_W;
    localparam int TSG_DIV_N     = 4;
    localparam int TSG_CPU_BIT   = 1;
    localparam int TSG_LATCH_LEN = 2;

    typedef enum logic [TSG_STATE_W-1:0] {
        ST_T1 = 2'd0,
        ST_T2 = 2'd1,
        ST_T3 = 2'd2,
        ST_T4 = 2'd3
    } tsg_state_e;

    localparam tsg_state_e TSG_LATCH_STATE = ST_T3;

    typedef struct packed {
        logic       cpu_slot;
        logic       addr_cpu;
        tsg_state_e state;
        logic       latch;
        logic       byte_hi;
    } tsg_timing_t;

    localparam tsg_timing_t TSG_TIMING_RST = '{
        cpu_slot: 1'b0, addr_cpu: 1'b0, state: ST_T1, latch: 1'b0, byte_hi: 1'b0
    };

    // Decode the slot, state and strobe fields from a count value
    function automatic tsg_timing_t decode_timing(input logic [TSG_CNT_W-1:0] c);
        tsg_timing_t t;
        logic [TSG_POS_W-1:0] pos;
        pos        = c[TSG_POS_W-1:0];
        t.cpu_slot = c[TSG_CNT_W-1];
        t.addr_cpu = c[TSG_CNT_W-1];
        t.state    = tsg_state_e'(c[TSG_CNT_W-2:TSG_POS_W]);
        t.latch    = !c[TSG_CNT_W-1] && (t.state == TSG_LATCH_STATE)
                     && (int'(pos) < TSG_LATCH_LEN);
        t.byte_hi  = t.latch && (int'(pos) >= TSG_LATCH_LEN / 2);
        return t;
    endfunction

endpackage

// File: rtl/tsg_counter.sv
module tsg_counter
    import tsg_pkg::*;
#(
    parameter int CNT_W = TSG_CNT_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    output logic [CNT_W-1:0] cnt_next_o
);

    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        cnt_next_o = rst_i ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        cnt_q <= cnt_next_o;
    end

    // R2 / R9: free-running count steps by one outside reset
    assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/tsg_clk_div.sv
module tsg_clk_div
    import tsg_pkg::*;
#(
    parameter int DIV_N   = TSG_DIV_N,
    parameter int CPU_BIT = TSG_CPU_BIT
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [DIV_N-1:0] cnt_next_i,
    output logic [DIV_N-1:0] div_o,
    output logic             cpu_clk_o,
    output logic             cpu_clk_n_o
);

    for (genvar k = 0; k < DIV_N; k++) begin : g_div
        always_ff @(posedge clk_i) begin
            div_o[k] <= rst_i ? 1'b0 : cnt_next_i[k];
        end
    end

    // Two separate flops form the complementary CPU clock pair
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cpu_clk_o   <= 1'b0;
            cpu_clk_n_o <= 1'b1;
        end else begin
            cpu_clk_o   <= cnt_next_i[CPU_BIT];
            cpu_clk_n_o <= ~cnt_next_i[CPU_BIT];
        end
    end

    // R2: the half-rate output toggles on every master edge
    assert_half_rate_toggle_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (div_o[0] != $past(div_o[0])));

    // R8: CPU clock pair never overlaps
    assert_cpu_pair_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (cpu_clk_n_o == ~cpu_clk_o));

endmodule

// File: rtl/tsg_slot_decode.sv
module tsg_slot_decode
    import tsg_pkg::*;
#(
    parameter int CNT_W = TSG_CNT_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [CNT_W-1:0] cnt_next_i,
    output tsg_timing_t      timing_o
);

    tsg_timing_t timing_d;

    always_comb begin
        timing_d = decode_timing(cnt_next_i);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) timing_o <= TSG_TIMING_RST;
        else       timing_o <= timing_d;
    end

    // R6: strobe only in the video slot
    assert_latch_in_video_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        timing_o.latch |-> !timing_o.cpu_slot);

    // R6 / R7: strobe starts in T3 with the high byte selected
    assert_latch_start_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(timing_o.latch) |-> (timing_o.state == TSG_LATCH_STATE) && !timing_o.byte_hi);

    // R7: byte select only inside the strobe
    assert_byte_in_latch_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        timing_o.byte_hi |-> timing_o.latch);

    // R5: state changes advance by one
    assert_state_step_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$stable(timing_o.state) && timing_o.state != ST_T1)
            |-> (timing_o.state == tsg_state_e'($past(timing_o.state) + 2'd1)));

    // R3 / R5: a new slot always begins in T1
    assert_slot_start_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(timing_o.cpu_slot) |-> (timing_o.state == ST_T1));

endmodule

// File: rtl/tsg_timing_gen.sv
module tsg_timing_gen
    import tsg_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_i,
    output logic [TSG_DIV_N-1:0] div_o,
    output logic                 slot_cpu_o,
    output logic                 addr_sel_o,
    output logic [1:0]           state_o,
    output logic                 latch_o,
    output logic                 byte_hi_o,
    output logic                 cpu_clk_o,
    output logic                 cpu_clk_n_o
);

    logic [TSG_CNT_W-1:0] cnt_next;
    tsg_timing_t          timing;

    tsg_counter #(.CNT_W(TSG_CNT_W)) u_counter (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .cnt_next_o (cnt_next)
    );

    tsg_clk_div #(.DIV_N(TSG_DIV_N), .CPU_BIT(TSG_CPU_BIT)) u_clk_div (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .cnt_next_i  (cnt_next[TSG_DIV_N-1:0]),
        .div_o       (div_o),
        .cpu_clk_o   (cpu_clk_o),
        .cpu_clk_n_o (cpu_clk_n_o)
    );

    tsg_slot_decode #(.CNT_W(TSG_CNT_W)) u_slot_decode (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .cnt_next_i (cnt_next),
        .timing_o   (timing)
    );

    assign slot_cpu_o = timing.cpu_slot;
    assign addr_sel_o = timing.addr_cpu;
    assign state_o    = timing.state;
    assign latch_o    = timing.latch;
    assign byte_hi_o  = timing.byte_hi;

    // R4: the address select follows the slot indicator
    assert_addr_sel_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (addr_sel_o == slot_cpu_o));

endmodule

// File: tb/tsg_timing_gen_tb.sv
module tsg_timing_gen_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] div;
    logic       slot_cpu, addr_sel, latch, byte_hi, cpu_clk, cpu_clk_n;
    logic [1:0] state;

    int checks   = 0;
    int failures = 0;
    logic [4:0] ref_cnt = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tsg_timing_gen dut_i (
        .clk_i(clk), .rst_i(rst), .div_o(div), .slot_cpu_o(slot_cpu),
        .addr_sel_o(addr_sel), .state_o(state), .latch_o(latch),
        .byte_hi_o(byte_hi), .cpu_clk_o(cpu_clk), .cpu_clk_n_o(cpu_clk_n)
    );

    // Reference position in the 32-clock period, per R2
    always @(posedge clk) ref_cnt <= rst ? 5'd0 : ref_cnt + 5'd1;

    function automatic logic [3:0] exp_div(input logic [4:0] c);   return c[3:0]; endfunction
    function automatic logic       exp_slot(input logic [4:0] c);  return c >= 5'd16; endfunction
    function automatic logic [1:0] exp_state(input logic [4:0] c); return c[3:2]; endfunction
    function automatic logic       exp_latch(input logic [4:0] c); return (c == 5'd8) || (c == 5'd9); endfunction
    function automatic logic       exp_byte(input logic [4:0] c);  return c == 5'd9; endfunction
    function automatic logic       exp_cpu(input logic [4:0] c);   return c[1]; endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s count=%0d actual=%0d expected=%0d", req, ref_cnt, act, exp);
        end
    endtask

    task automatic check_all();
        check("R2 div",       div,       exp_div(ref_cnt));
        check("R3 slot",      slot_cpu,  exp_slot(ref_cnt));
        check("R4 addr_sel",  addr_sel,  exp_slot(ref_cnt));
        check("R5 state",     state,     exp_state(ref_cnt));
        check("R6 latch",     latch,     exp_latch(ref_cnt));
        check("R7 byte_hi",   byte_hi,   exp_byte(ref_cnt));
        check("R8 cpu_clk",   cpu_clk,   exp_cpu(ref_cnt));
        check("R8 cpu_clk_n", cpu_clk_n, !exp_cpu(ref_cnt));
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_all();
        end
    endtask

    task automatic check_reset_state(input string req);
        check({req, " div"},       div,       0);
        check({req, " slot"},      slot_cpu,  0);
        check({req, " addr_sel"},  addr_sel,  0);
        check({req, " state"},     state,     0);
        check({req, " latch"},     latch,     0);
        check({req, " byte_hi"},   byte_hi,   0);
        check({req, " cpu_clk"},   cpu_clk,   0);
        check({req, " cpu_clk_n"}, cpu_clk_n, 1);
    endtask

    int latch_cycles;

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd4242));
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_state("R1");
        rst = 1'b0;
        // Directed: two full periods, counting strobe cycles (R6)
        latch_cycles = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            check_all();
            if (latch) latch_cycles++;
        end
        check("R6 strobe clocks per 64", latch_cycles, 4);
        // R9 corner: reset exactly during the strobe second clock
        while (ref_cnt != 5'd9) @(negedge clk);
        check("R7 second strobe clock", byte_hi, 1);
        rst = 1'b1;
        @(negedge clk);
        check_reset_state("R9 mid-strobe");
        rst = 1'b0;
        run(40);
        // Random segments with resets at random points
        for (int s = 0; s < 30; s++) begin
            run(1 + int'($urandom_range(120)));
            rst = 1'b1;
            repeat (1 + int'($urandom_range(2))) @(negedge clk);
            check_reset_state("R9");
            rst = 1'b0;
        end
        run(70);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule